// File: doc/BRIEF.md
# Display Window Write Sequencer

This block feeds a serial display controller that has a separate command/data select line beside the usual serial clock, data and chip select. After bringing the panel out of reset with a timed power-on pulse, it accepts one request at a time. A window request names a start and end column and a start and end row in the panel's address space, plus a pixel mode. A command request sends a single opcode followed by up to a few parameter bytes.

For a window the sequencer sends the address-window commands and then the memory-write command, toggling the select line so that opcodes go out as commands and their arguments as data. It then pulls pixels from a valid/ready input stream and shifts them out row by row. In grayscale mode each stream beat supplies one byte. In colour mode each beat is a 32-bit RGBA pixel that becomes three 6-bit colour bytes. A colour panel mounted upside down needs its row addresses shifted, so the request carries a flip flag that applies that offset.

Top module: `dwin_seq`

## Requirements
- R1: After reset, `lcd_rst_n` stays low for POR_CYCLES clocks, then goes high, and `busy` stays high for a further POR_CYCLES clocks. Requests that arrive during this time are dropped. Once high, `lcd_rst_n` never falls again.
- R2: Each byte is framed by `spi_cs_n` low for exactly 16×SCK_HALF clocks. The bits go MSB first in SPI mode 0: `spi_sclk` idles low and is low whenever `spi_cs_n` is high, `spi_mosi` changes only on falling edges, and each clock level lasts SCK_HALF clocks.
- R3: A window request (`req_op`=0) sends the following bytes in order: row-address opcode (0x75), start row, end row, column-address opcode (0x15), start column, end column, memory-write opcode (0x5C), and then the pixel bytes of each row in turn from the first row to the last. `lcd_dc` is 0 for the three opcodes and 1 for every other byte.
- R4: In grayscale mode (`req_color`=0) each row has (end column − start column + 1)×2 bytes. Each byte is bits [7:0] of one stream beat.
- R5: In colour mode (`req_color`=1) each row has (end column − start column + 1)×3 bytes. Each beat supplies a pixel: R in [31:24], G in [23:16] and B in [15:8]. The pixel is sent as R>>2, then G>>2, then B>>2. Bits [7:0] are discarded.
- R6: In colour mode with `req_flip`=1, both row bytes are increased by 132 − PANEL_H, modulo 256. In grayscale mode the flip flag has no effect.
- R7: A command request (`req_op`=1) sends `req_len` bytes, each taken from bits [7:0] of one beat. The first byte has `lcd_dc`=0. The remaining bytes have `lcd_dc`=1, or 0 when `req_late_dc`=1.
- R8: `lcd_dc` changes only while `spi_cs_n` is high, never during a byte.
- R9: `busy` rises on the clock after a request is accepted and stays high until the last byte has been fully shifted out. Requests made while `busy` is high are ignored. `px_ready` is asserted only while busy.
- R10: A window with end column < start column or end row < start row, or a command with `req_len`=0, is rejected. A rejected request gives a one-cycle `req_err` pulse on the next clock, sends nothing and leaves `busy` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when not busy |
| req_op | input | 1 | 0 = window write, 1 = command |
| req_color | input | 1 | 1 = 18-bit colour mode, 0 = grayscale |
| req_flip | input | 1 | Apply row offset in colour mode |
| req_late_dc | input | 1 | Keep select low for command parameters |
| req_col_start | input | 8 | First column |
| req_col_end | input | 8 | Last column |
| req_row_start | input | 8 | First row |
| req_row_end | input | 8 | Last row |
| req_len | input | LEN_W | Command byte count |
| busy | output | 1 | Power-on or transfer in progress |
| req_err | output | 1 | Rejected-request pulse |
| px_data | input | 32 | Stream beat (pixel or byte) |
| px_valid | input | 1 | Beat available |
| px_ready | output | 1 | Beat consumed this cycle |
| lcd_rst_n | output | 1 | Panel reset, active low |
| lcd_dc | output | 1 | Command (0) / data (1) select |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data |
| spi_cs_n | output | 1 | Chip select, active low |

## Verification
The bench targets the boundaries of a window: a single pixel, where column and row lengths are one, and a flipped colour window whose start row of 254 wraps past 255. A design that got the count wrong would stop one beat early or late. A design that ignored the flip or the wrap would send the wrong row addresses. Command requests of length one and with the late-select option check that the select line stays low only where it should; a sequencer that toggled it eagerly would mark parameters as data. Stalls on the input stream, a second request pushed in mid-transfer, and malformed windows show whether a design drops bytes, starts a second transfer, or fails to raise the error pulse.

// File: rtl/dwin_pkg.sv
package dwin_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_HDR,
    S_PIX,
    S_CMD,
    S_DRAIN
  } seq_st_t;

  localparam logic OP_WINDOW = 1'b0;
  localparam logic OP_CMD    = 1'b1;
  localparam int   HDR_LAST  = 6;
endpackage

// File: rtl/dwin_por.sv
module dwin_por #(
  parameter int CYC = 12500
) (
  input  logic clk,
  input  logic rst,
  output logic rst_n_o,
  output logic done_o
);
  localparam int CW = $clog2(CYC + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      rst_n_o <= 1'b0;
      done_o  <= 1'b0;
    end else if (!done_o) begin
      if (cnt == CW'(CYC - 1)) begin
        cnt <= '0;
        if (!rst_n_o) rst_n_o <= 1'b1;
        else          done_o  <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/dwin_spi_tx.sv
module dwin_spi_tx #(
  parameter int HALF = 7
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [7:0] din,
  output logic       idle,
  output logic       sclk,
  output logic       mosi,
  output logic       cs_n
);
  localparam int DW = (HALF > 1) ? $clog2(HALF) : 1;
  logic [DW-1:0] div;
  logic [2:0]    bitn;
  logic [7:0]    sh;
  logic          act;

  assign idle = !act;

  always_ff @(posedge clk) begin
    if (rst) begin
      act  <= 1'b0;
      div  <= '0;
      bitn <= '0;
      sh   <= '0;
      sclk <= 1'b0;
      mosi <= 1'b0;
      cs_n <= 1'b1;
    end else if (!act) begin
      if (start) begin
        act  <= 1'b1;
        sh   <= din;
        mosi <= din[7];
        cs_n <= 1'b0;
        sclk <= 1'b0;
        div  <= '0;
        bitn <= '0;
      end
    end else if (div == DW'(HALF - 1)) begin
      div <= '0;
      if (!sclk) begin
        sclk <= 1'b1;
      end else begin
        sclk <= 1'b0;
        if (bitn == 3'd7) begin
          act  <= 1'b0;
          cs_n <= 1'b1;
          mosi <= 1'b0;
        end else begin
          bitn <= bitn + 1'b1;
          sh   <= {sh[6:0], 1'b0};
          mosi <= sh[6];
        end
      end
    end else begin
      div <= div + 1'b1;
    end
  end
endmodule

// File: rtl/dwin_pix_fmt.sv
module dwin_pix_fmt (
  input  logic        color,
  input  logic [1:0]  sub,
  input  logic [31:0] data,
  output logic [7:0]  byte_o
);
  always_comb begin
    if (!color) begin
      byte_o = data[7:0];
    end else begin
      case (sub)
        2'd0:    byte_o = {2'b00, data[31:26]};
        2'd1:    byte_o = {2'b00, data[23:18]};
        default: byte_o = {2'b00, data[15:10]};
      endcase
    end
  end
endmodule

// File: rtl/dwin_seq.sv
module dwin_seq #(
  parameter int         POR_CYCLES = 12500,
  parameter int         SCK_HALF   = 7,
  parameter int         PANEL_H    = 128,
  parameter int         LEN_W      = 5,
  parameter logic [7:0] G_ROW_OP   = 8'h75,
  parameter logic [7:0] G_COL_OP   = 8'h15,
  parameter logic [7:0] G_WR_OP    = 8'h5C,
  parameter logic [7:0] C_ROW_OP   = 8'h75,
  parameter logic [7:0] C_COL_OP   = 8'h15,
  parameter logic [7:0] C_WR_OP    = 8'h5C
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             req_op,
  input  logic             req_color,
  input  logic             req_flip,
  input  logic             req_late_dc,
  input  logic [7:0]       req_col_start,
  input  logic [7:0]       req_col_end,
  input  logic [7:0]       req_row_start,
  input  logic [7:0]       req_row_end,
  input  logic [LEN_W-1:0] req_len,
  output logic             busy,
  output logic             req_err,
  input  logic [31:0]      px_data,
  input  logic             px_valid,
  output logic             px_ready,
  output logic             lcd_rst_n,
  output logic             lcd_dc,
  output logic             spi_sclk,
  output logic             spi_mosi,
  output logic             spi_cs_n
);
  import dwin_pkg::*;

  localparam logic [7:0] ROW_OFS = 8'(132 - PANEL_H);

  seq_st_t          st;
  logic [2:0]       idx;
  logic [7:0]       rows_left;
  logic [9:0]       bcnt;
  logic [1:0]       sub;
  logic [LEN_W-1:0] k;
  logic             r_color, r_flip, r_late;
  logic [7:0]       r_cs, r_ce, r_rs, r_re;
  logic [LEN_W-1:0] r_len;

  logic       por_done, tx_idle, launch, have, pop, tx_dc, hdr_dc;
  logic [7:0] tx_byte, hdr_byte, fmt_byte, row_ofs;
  logic [8:0] npix;
  logic [9:0] rowlen_m1;
  logic       bad_req;

  dwin_por #(.CYC(POR_CYCLES)) u_por (
    .clk(clk), .rst(rst), .rst_n_o(lcd_rst_n), .done_o(por_done)
  );

  dwin_spi_tx #(.HALF(SCK_HALF)) u_tx (
    .clk(clk), .rst(rst), .start(launch), .din(tx_byte),
    .idle(tx_idle), .sclk(spi_sclk), .mosi(spi_mosi), .cs_n(spi_cs_n)
  );

  dwin_pix_fmt u_fmt (
    .color(r_color), .sub(sub), .data(px_data), .byte_o(fmt_byte)
  );

  assign npix      = {1'b0, r_ce - r_cs} + 9'd1;
  assign rowlen_m1 = r_color ? ({1'b0, npix} + {npix, 1'b0} - 10'd1)
                             : ({npix, 1'b0} - 10'd1);
  assign row_ofs   = (r_color && r_flip) ? ROW_OFS : 8'd0;
  assign bad_req   = (req_op == OP_CMD) ? (req_len == '0)
                   : ((req_col_end < req_col_start) || (req_row_end < req_row_start));

  always_comb begin
    case (idx)
      3'd0:    hdr_byte = r_color ? C_ROW_OP : G_ROW_OP;
      3'd1:    hdr_byte = r_rs + row_ofs;
      3'd2:    hdr_byte = r_re + row_ofs;
      3'd3:    hdr_byte = r_color ? C_COL_OP : G_COL_OP;
      3'd4:    hdr_byte = r_cs;
      3'd5:    hdr_byte = r_ce;
      default: hdr_byte = r_color ? C_WR_OP : G_WR_OP;
    endcase
    hdr_dc = !(idx == 3'd0 || idx == 3'd3 || idx == 3'(HDR_LAST));
  end

  always_comb begin
    tx_byte = hdr_byte;
    tx_dc   = hdr_dc;
    have    = 1'b0;
    pop     = 1'b0;
    case (st)
      S_HDR: have = 1'b1;
      S_PIX: begin
        have    = px_valid;
        tx_byte = fmt_byte;
        tx_dc   = 1'b1;
        pop     = !r_color || (sub == 2'd2);
      end
      S_CMD: begin
        have    = px_valid;
        tx_byte = px_data[7:0];
        tx_dc   = (k != '0) && !r_late;
        pop     = 1'b1;
      end
      default: ;
    endcase
  end

  assign launch   = have && tx_idle;
  assign px_ready = launch && pop;
  assign busy     = !por_done || (st != S_IDLE);
  assign lcd_dc   = tx_dc_q;

  logic tx_dc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      idx       <= '0;
      rows_left <= '0;
      bcnt      <= '0;
      sub       <= '0;
      k         <= '0;
      r_color   <= 1'b0;
      r_flip    <= 1'b0;
      r_late    <= 1'b0;
      r_cs      <= '0;
      r_ce      <= '0;
      r_rs      <= '0;
      r_re      <= '0;
      r_len     <= '0;
      tx_dc_q   <= 1'b0;
      req_err   <= 1'b0;
    end else begin
      req_err <= 1'b0;
      case (st)
        S_IDLE: if (por_done && req_valid) begin
          if (bad_req) begin
            req_err <= 1'b1;
          end else begin
            r_color   <= req_color;
            r_flip    <= req_flip;
            r_late    <= req_late_dc;
            r_cs      <= req_col_start;
            r_ce      <= req_col_end;
            r_rs      <= req_row_start;
            r_re      <= req_row_end;
            r_len     <= req_len;
            rows_left <= req_row_end - req_row_start;
            idx       <= '0;
            bcnt      <= '0;
            sub       <= '0;
            k         <= '0;
            st        <= (req_op == OP_CMD) ? S_CMD : S_HDR;
          end
        end
        S_HDR: if (launch) begin
          tx_dc_q <= tx_dc;
          idx     <= idx + 1'b1;
          if (idx == 3'(HDR_LAST)) st <= S_PIX;
        end
        S_PIX: if (launch) begin
          tx_dc_q <= 1'b1;
          sub     <= (r_color && sub != 2'd2) ? sub + 1'b1 : 2'd0;
          if (bcnt == rowlen_m1) begin
            bcnt <= '0;
            if (rows_left == 8'd0) st <= S_DRAIN;
            else                   rows_left <= rows_left - 1'b1;
          end else begin
            bcnt <= bcnt + 1'b1;
          end
        end
        S_CMD: if (launch) begin
          tx_dc_q <= tx_dc;
          k       <= k + 1'b1;
          if (k == r_len - 1'b1) st <= S_DRAIN;
        end
        S_DRAIN: if (tx_idle) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dwin_seq_chk.sv
module dwin_seq_chk #(
  parameter int SCK_HALF = 7
) (
  input logic clk,
  input logic rst,
  input logic req_valid,
  input logic busy,
  input logic req_err,
  input logic px_valid,
  input logic px_ready,
  input logic lcd_rst_n,
  input logic lcd_dc,
  input logic spi_sclk,
  input logic spi_cs_n
);
  AST_DC_BETWEEN_BYTES: assert property (@(posedge clk) disable iff (rst)
    !$stable(lcd_dc) |-> $past(spi_cs_n)); // R8
  AST_DC_HELD_IN_BYTE: assert property (@(posedge clk) disable iff (rst)
    (!spi_cs_n && !$past(spi_cs_n)) |-> $stable(lcd_dc)); // R8
  AST_SCLK_FRAMED: assert property (@(posedge clk) disable iff (rst)
    spi_sclk |-> !spi_cs_n); // R2
  AST_RST_STAYS_HIGH: assert property (@(posedge clk) disable iff (rst)
    $past(lcd_rst_n) |-> lcd_rst_n); // R1
  AST_POR_BUSY: assert property (@(posedge clk) disable iff (rst)
    !lcd_rst_n |-> busy); // R1
  AST_CS_BUSY: assert property (@(posedge clk) disable iff (rst)
    !spi_cs_n |-> busy); // R9
  AST_PX_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
    px_ready |-> (busy && px_valid)); // R9
  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (rst)
    req_err |-> (!busy && $past(req_valid))); // R10

  generate
    if (SCK_HALF > 1) begin : g_hold
      AST_SCLK_HOLD: assert property (@(posedge clk) disable iff (rst)
        !$stable(spi_sclk) |=> $stable(spi_sclk)); // R2
    end
  endgenerate
endmodule

bind dwin_seq dwin_seq_chk #(.SCK_HALF(SCK_HALF)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .busy(busy), .req_err(req_err),
  .px_valid(px_valid), .px_ready(px_ready), .lcd_rst_n(lcd_rst_n),
  .lcd_dc(lcd_dc), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n)
);

// File: tb/tb_dwin_seq.sv
`timescale 1ns/1ps
module tb_dwin_seq;
  localparam int POR = 30;
  localparam int HALF = 2;
  localparam int LW = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_op = 1'b0, req_color = 1'b0, req_flip = 1'b0, req_late_dc = 1'b0;
  logic [7:0] req_col_start = '0, req_col_end = '0, req_row_start = '0, req_row_end = '0;
  logic [LW-1:0] req_len = '0;
  logic busy, req_err, px_ready, lcd_rst_n, lcd_dc, spi_sclk, spi_mosi, spi_cs_n;
  logic px_valid = 1'b0;
  logic [31:0] px_data;
  int beat = 0;

  always #4 clk = ~clk;

  function automatic logic [31:0] gen_px(int i);
    logic [31:0] v;
    v = 32'(i) * 32'h9E3779B1;
    return v ^ (v >> 13) ^ 32'h5A3C_0F17;
  endfunction

  assign px_data = gen_px(beat);

  dwin_seq #(.POR_CYCLES(POR), .SCK_HALF(HALF), .LEN_W(LW)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op), .req_color(req_color),
    .req_flip(req_flip), .req_late_dc(req_late_dc), .req_col_start(req_col_start),
    .req_col_end(req_col_end), .req_row_start(req_row_start), .req_row_end(req_row_end),
    .req_len(req_len), .busy(busy), .req_err(req_err), .px_data(px_data),
    .px_valid(px_valid), .px_ready(px_ready), .lcd_rst_n(lcd_rst_n), .lcd_dc(lcd_dc),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_cs_n(spi_cs_n)
  );

  always @(posedge clk) if (px_valid && px_ready) beat <= beat + 1;
  always @(negedge clk) if (!rst) px_valid <= ($urandom_range(0, 3) != 0);

  // serial receiver
  logic [7:0] rcv_b [0:4095];
  logic       rcv_dc [0:4095];
  int rcv_n = 0, bitc = 0, dc_glitch = 0, bad_frame = 0, lowc = 0;
  logic [7:0] shin = '0;
  logic dc_first = 1'b0;

  always @(posedge spi_sclk) if (!spi_cs_n) begin
    if (bitc == 0) dc_first = lcd_dc;
    shin = {shin[6:0], spi_mosi};
    bitc++;
    if (bitc == 8) begin
      if (lcd_dc != dc_first) dc_glitch++;
      if (rcv_n < 4096) begin
        rcv_b[rcv_n] = shin;
        rcv_dc[rcv_n] = lcd_dc;
      end
      rcv_n++;
      bitc = 0;
    end
  end

  always @(negedge clk) begin
    if (!spi_cs_n) lowc++;
    else if (lowc != 0) begin
      if (lowc != 16 * HALF) bad_frame++;
      lowc = 0;
    end
  end

  int checks = 0, fails = 0;
  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // expected stream
  logic [7:0] exp_b [0:4095];
  logic       exp_dc [0:4095];
  int exp_n, exp_beats;

  task automatic push(logic [7:0] b, logic d);
    exp_b[exp_n] = b;
    exp_dc[exp_n] = d;
    exp_n++;
  endtask

  task automatic build(bit op, bit color, bit flip, bit late, int cs, int ce, int rs, int re, int len);
    int b;
    logic [7:0] ofs;
    logic [31:0] p;
    exp_n = 0;
    b = beat;
    if (op) begin
      for (int i = 0; i < len; i++) begin
        p = gen_px(b++);
        push(p[7:0], (i == 0) ? 1'b0 : !late);
      end
    end else begin
      ofs = (color && flip) ? 8'(132 - 128) : 8'd0;
      push(8'h75, 0); push(8'(rs) + ofs, 1); push(8'(re) + ofs, 1);
      push(8'h15, 0); push(8'(cs), 1); push(8'(ce), 1); push(8'h5C, 0);
      for (int r = rs; r <= re; r++) begin
        if (color) begin
          for (int c = cs; c <= ce; c++) begin
            p = gen_px(b++);
            push({2'b00, p[31:26]}, 1); push({2'b00, p[23:18]}, 1); push({2'b00, p[15:10]}, 1);
          end
        end else begin
          for (int j = 0; j < 2 * (ce - cs + 1); j++) begin
            p = gen_px(b++);
            push(p[7:0], 1);
          end
        end
      end
    end
    exp_beats = b - beat;
  endtask

  task automatic drive(bit op, bit color, bit flip, bit late, int cs, int ce, int rs, int re, int len);
    req_op = op; req_color = color; req_flip = flip; req_late_dc = late;
    req_col_start = 8'(cs); req_col_end = 8'(ce);
    req_row_start = 8'(rs); req_row_end = 8'(re); req_len = LW'(len);
  endtask

  task automatic run_op(bit op, bit color, bit flip, bit late, int cs, int ce, int rs, int re,
                        int len, string tag, bit inject);
    int n0, b0, mism, first;
    build(op, color, flip, late, cs, ce, rs, re, len);
    n0 = rcv_n; b0 = beat;
    @(negedge clk);
    drive(op, color, flip, late, cs, ce, rs, re, len);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy === 1'b1, "R9 busy after accept", int'(busy), 1);
    if (inject) begin
      repeat (40) @(negedge clk);
      drive(1'b1, 1'b0, 1'b0, 1'b0, 0, 0, 0, 0, 3);
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
    end
    while (busy) @(negedge clk);
    chk(rcv_n - n0 == exp_n, {tag, " byte count"}, rcv_n - n0, exp_n);
    mism = 0; first = -1;
    for (int i = 0; i < exp_n && n0 + i < rcv_n; i++)
      if (rcv_b[n0 + i] !== exp_b[i] || rcv_dc[n0 + i] !== exp_dc[i]) begin
        mism++;
        if (first < 0) first = i;
      end
    if (first < 0) chk(1'b1, tag, 0, 0);
    else chk(1'b0, {tag, " byte/dc at index"}, {23'd0, rcv_dc[n0 + first], rcv_b[n0 + first]},
             {23'd0, exp_dc[first], exp_b[first]});
    chk(beat - b0 == exp_beats, {tag, " beats consumed"}, beat - b0, exp_beats);
  endtask

  task automatic run_bad(bit op, int cs, int ce, int rs, int re, int len);
    int n0;
    n0 = rcv_n;
    @(negedge clk);
    drive(op, 1'b0, 1'b0, 1'b0, cs, ce, rs, re, len);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_err === 1'b1 && busy === 1'b0, "R10 error pulse", {30'd0, req_err, busy}, 2);
    repeat (40) @(negedge clk);
    chk(rcv_n == n0 && busy === 1'b0 && req_err === 1'b0, "R10 nothing sent", rcv_n - n0, 0);
  endtask

  bit done = 0;

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int lowcnt, waitcnt, n0;
    void'($urandom(32'h00C0FFEE));
    repeat (5) @(negedge clk);
    chk(busy === 1'b1 && spi_cs_n === 1'b1 && spi_sclk === 1'b0 && lcd_rst_n === 1'b0,
        "R1 reset state", {28'd0, busy, spi_cs_n, spi_sclk, lcd_rst_n}, 4'b1100);
    rst = 1'b0;
    n0 = rcv_n;
    drive(1'b0, 1'b0, 1'b0, 1'b0, 0, 0, 0, 0, 1);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    lowcnt = 1;
    while (!lcd_rst_n) begin @(negedge clk); lowcnt++; end
    chk(lowcnt >= POR - 1 && lowcnt <= POR + 1, "R1 reset low time", lowcnt, POR);
    waitcnt = 0;
    while (busy) begin @(negedge clk); waitcnt++; end
    chk(waitcnt >= POR - 1 && waitcnt <= POR + 1, "R1 post-reset wait", waitcnt, POR);
    repeat (20) @(negedge clk);
    chk(rcv_n == n0 && busy === 1'b0, "R1 request during power-on ignored", rcv_n - n0, 0);

    run_op(0, 0, 0, 0, 5, 5, 9, 9, 1, "R4 gray 1x1", 0);
    run_op(0, 0, 1, 0, 10, 12, 3, 4, 1, "R6 gray flip ignored", 0);
    run_op(0, 1, 0, 0, 0, 0, 0, 0, 1, "R5 colour 1x1", 0);
    run_op(0, 1, 1, 0, 20, 22, 254, 255, 1, "R6 colour flip wrap", 0);
    run_op(0, 1, 0, 0, 2, 4, 7, 8, 1, "R3 colour sequence", 1);
    run_op(1, 0, 0, 0, 0, 0, 0, 0, 1, "R7 command single", 0);
    run_op(1, 0, 0, 1, 0, 0, 0, 0, 4, "R7 command late select", 0);
    run_op(1, 0, 0, 0, 0, 0, 0, 0, 4, "R7 command early select", 0);
    run_bad(0, 9, 8, 0, 0, 1);
    run_bad(0, 0, 0, 6, 5, 1);
    run_bad(1, 0, 0, 0, 0, 0);

    for (int it = 0; it < 16; it++) begin
      int cs, rs;
      bit op, col;
      op = ($urandom_range(0, 3) == 0);
      col = 1'($urandom_range(0, 1));
      cs = $urandom_range(0, 250);
      rs = $urandom_range(0, 252);
      if (op)
        run_op(1, 0, 0, 1'($urandom_range(0, 1)), 0, 0, 0, 0, $urandom_range(1, 6),
               "R7 random command", 0);
      else
        run_op(0, col, 1'($urandom_range(0, 1)), 0, cs, cs + $urandom_range(0, 3),
               rs, rs + $urandom_range(0, 2), 1, col ? "R5 random colour" : "R4 random gray", 0);
    end

    chk(bad_frame == 0, "R2 byte frame length", bad_frame, 0);
    chk(dc_glitch == 0, "R8 select stable within byte", dc_glitch, 0);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule